// File: doc/BRIEF.md
# Shared Address/Data Bus Memory Front End

This block sits between a microcontroller's external memory bus and an internal byte-wide storage array. The controller shares eight pins between the low address byte and data, and seven more pins carry the high address bits. An address-latch strobe marks the address phase. One active-low chip select and three active-low strobes follow: a program-read strobe, a data-read strobe and a write strobe. Both read strobes reach the same array, so one device can be both program memory and data memory. A part used only as program memory ties the data-read and write strobes high.

All bus inputs pass through a synchronizer of `SYNC_STAGES` flops and are edge-detected in the system clock. The block keeps a 15-bit address that follows the bus while the latch strobe is high and holds from its falling edge. A falling read strobe produces a one-cycle read request. The downstream side answers on `rsp_data` with the byte for the request address, or with status. That byte is then driven back on the shared pins while the read strobe is held. A rising write strobe produces a one-cycle write request that carries the held address and the last byte seen while the strobe was low.

Both request outputs are valid-only streams with an implied ready that is always high. There is no back-pressure: a consumer must take every pulse in the cycle it appears. `rd_addr` holds its value until the next read request, and `rsp_data` must follow `rd_addr` combinationally.

Top module: `mux_bus_if`

## Requirements
- R1: The working address is 15 bits wide. Bits 14..8 come from `hi_addr` and bits 7..0 from `ad_in`, both sampled during the address phase.
- R2: While the synchronized latch strobe is high, a read request reports the live bus address. Once the strobe has fallen, the address sampled in the last cycle it was high is held, whatever the pins do afterwards.
- R3: When the synchronized `cs_n` is high, no read request and no write request are issued and `ad_oe` stays low.
- R4: A falling edge on the combined read strobe (`prd_n` low or `drd_n` low) with chip select low issues a `rd_valid` pulse of exactly one cycle. `rd_space` is 0 when `prd_n` is low and 1 when only `drd_n` is low.
- R5: `ad_oe` is high exactly one cycle after chip select and a read strobe are both sampled low. While `ad_oe` is high, `ad_out` carries the `rsp_data` seen one cycle earlier.
- R6: On a rising edge of the synchronized write strobe, a one-cycle `wr_valid` pulse carries the held address and the bus byte from the last cycle in which the write strobe was low.
- R7: A write strobe whose last low cycle had a read strobe low, or chip select high, issues no write request.
- R8: With `drd_n` and `wr_n` tied high, program reads alone produce read requests with `rd_space` equal to 0, and no write request ever appears.
- R9: After reset, `ad_oe`, `rd_valid` and `wr_valid` are 0, and `rd_addr` and `ad_out` are 0.
- R10: A strobe change driven on the pins shows up at the request outputs after `SYNC_STAGES`+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe, active high |
| cs_n | input | 1 | Chip select, active low |
| prd_n | input | 1 | Program-read strobe, active low |
| drd_n | input | 1 | Data-read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hi_addr | input | 7 | High address bits 14..8 |
| ad_in | input | 8 | Shared bus pins, input side |
| ad_out | output | 8 | Shared bus pins, output side |
| ad_oe | output | 1 | Output enable for the shared pins |
| rd_valid | output | 1 | One-cycle read request |
| rd_addr | output | 15 | Address of the latest read request (held) |
| rd_space | output | 1 | 0 for a program read, 1 for a data read |
| rsp_data | input | 8 | Byte returned for `rd_addr` |
| wr_valid | output | 1 | One-cycle write request |
| wr_addr | output | 15 | Write request address |
| wr_data | output | 8 | Write request byte |

## Verification
A corrupted held address shows up in the next read or write request as the wrong `rd_addr` or `wr_addr`. A stale edge-detect register shows up as a missing, doubled or spurious `rd_valid` or `wr_valid` pulse, seen `SYNC_STAGES`+1 edges after the strobe moves. A wrong enable state shows up on `ad_oe` in the cycle after the strobe or select is sampled, so bus contention in the address phase is visible at once. A bad write-data capture shows up only when the write strobe rises, in `wr_data`.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int LO_W   = 8;
  localparam int HI_W   = 7;
  localparam int ADDR_W = LO_W + HI_W;

  // one snapshot of every bus pin
  typedef struct packed {
    logic            ale;
    logic            cs_n;
    logic            prd_n;
    logic            drd_n;
    logic            wr_n;
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] ad;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);

  // quiet bus: latch closed, every active-low strobe high
  function automatic bus_smp_t idle_smp();
    bus_smp_t s;
    s.ale   = 1'b0;
    s.cs_n  = 1'b1;
    s.prd_n = 1'b1;
    s.drd_n = 1'b1;
    s.wr_n  = 1'b1;
    s.hi    = '0;
    s.ad    = '0;
    return s;
  endfunction
endpackage

// File: rtl/mbi_sync.sv
module mbi_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbi_addr_latch.sv
module mbi_addr_latch
  import mbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_s,
  input  logic [HI_W-1:0]   hi_s,
  input  logic [LO_W-1:0]   lo_s,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] held_addr
);
  logic [ADDR_W-1:0] live;

  assign live = {hi_s, lo_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_addr <= '0;
    else if (open_s) held_addr <= live;
  end

  // transparent while open, frozen once it closes
  assign cur_addr = open_s ? live : held_addr;
endmodule

// File: rtl/mbi_strobe_dec.sv
module mbi_strobe_dec
  import mbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              prd_n_s,
  input  logic              drd_n_s,
  input  logic              wr_n_s,
  input  logic [LO_W-1:0]   ad_s,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              rd_low_s,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_space,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LO_W-1:0]   wr_data
);
  logic            rd_low_p;
  logic            wr_n_p;
  logic            wok_q;
  logic [LO_W-1:0] wdat_q;
  logic            rd_fall;
  logic            wr_rise;

  assign rd_low_s = !prd_n_s || !drd_n_s;
  assign rd_fall  = rd_low_s && !rd_low_p && !cs_n_s;
  assign wr_rise  = wr_n_s && !wr_n_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_low_p <= 1'b0;
      wr_n_p   <= 1'b1;
      wok_q    <= 1'b0;
      wdat_q   <= '0;
    end else begin
      rd_low_p <= rd_low_s;
      wr_n_p   <= wr_n_s;
      // qualify each low cycle; the last one before the rise decides
      wok_q    <= !wr_n_s && !cs_n_s && !rd_low_s;
      if (!wr_n_s) wdat_q <= ad_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_space <= 1'b0;
    end else begin
      rd_valid <= rd_fall;
      if (rd_fall) begin
        rd_addr  <= cur_addr;
        rd_space <= prd_n_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= wr_rise && wok_q;
      if (wr_rise && wok_q) begin
        wr_addr <= cur_addr;
        wr_data <= wdat_q;
      end
    end
  end
endmodule

// File: rtl/mbi_bus_drive.sv
module mbi_bus_drive
  import mbi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_s,
  input  logic            rd_low_s,
  input  logic [LO_W-1:0] rsp_data,
  output logic [LO_W-1:0] ad_out,
  output logic            ad_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_oe  <= 1'b0;
      ad_out <= '0;
    end else begin
      ad_oe  <= !cs_n_s && rd_low_s;
      ad_out <= rsp_data;
    end
  end
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
  import mbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              prd_n,
  input  logic              drd_n,
  input  logic              wr_n,
  input  logic [HI_W-1:0]   hi_addr,
  input  logic [LO_W-1:0]   ad_in,
  output logic [LO_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_space,
  input  logic [LO_W-1:0]   rsp_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LO_W-1:0]   wr_data
);
  bus_smp_t          raw;
  bus_smp_t          smp;
  logic [SMP_W-1:0]  smp_vec;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] held_addr;
  logic              rd_low_s;
  logic              ale_s;
  logic              cs_n_s;

  always_comb begin
    raw.ale   = ale;
    raw.cs_n  = cs_n;
    raw.prd_n = prd_n;
    raw.drd_n = drd_n;
    raw.wr_n  = wr_n;
    raw.hi    = hi_addr;
    raw.ad    = ad_in;
  end

  mbi_sync #(
    .W       (SMP_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (idle_smp())
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (smp_vec)
  );

  assign smp    = bus_smp_t'(smp_vec);
  assign ale_s  = smp.ale;
  assign cs_n_s = smp.cs_n;

  mbi_addr_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_s    (ale_s),
    .hi_s      (smp.hi),
    .lo_s      (smp.ad),
    .cur_addr  (cur_addr),
    .held_addr (held_addr)
  );

  mbi_strobe_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .prd_n_s  (smp.prd_n),
    .drd_n_s  (smp.drd_n),
    .wr_n_s   (smp.wr_n),
    .ad_s     (smp.ad),
    .cur_addr (cur_addr),
    .rd_low_s (rd_low_s),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_space (rd_space),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  mbi_bus_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .rd_low_s (rd_low_s),
    .rsp_data (rsp_data),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe)
  );
endmodule

// File: rtl/mbi_checker.sv
module mbi_checker
  import mbi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ale_s,
  input logic              cs_n_s,
  input logic              rd_low_s,
  input logic [ADDR_W-1:0] held_addr,
  input logic              rd_valid,
  input logic              wr_valid,
  input logic              ad_oe
);
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_rd_drives_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ad_oe);

  assert_hold_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && $past(!ale_s)) |-> $stable(held_addr));

  assert_rd_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(cs_n_s));

  // the strobe's last low cycle sits two samples back
  assert_wr_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (!$past(cs_n_s, 2) && !$past(rd_low_s, 2)));
endmodule

bind mux_bus_if mbi_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale_s     (ale_s),
  .cs_n_s    (cs_n_s),
  .rd_low_s  (rd_low_s),
  .held_addr (held_addr),
  .rd_valid  (rd_valid),
  .wr_valid  (wr_valid),
  .ad_oe     (ad_oe)
);

// File: tb/sim_mux_bus_if.sv
module sim_mux_bus_if;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0, cs_n = 1'b1, prd_n = 1'b1, drd_n = 1'b1, wr_n = 1'b1;
  logic [6:0]  hi_addr = '0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic        rd_valid;
  logic [14:0] rd_addr;
  logic        rd_space;
  logic [7:0]  rsp_data;
  logic        wr_valid;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int errors = 0;
  int rd_seen = 0;
  int wr_seen = 0;
  int prog_seen = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rsp_f(input logic [14:0] a);
    return (a[7:0] ^ {1'b0, a[14:8]}) + 8'h5A;
  endfunction

  assign rsp_data = rsp_f(rd_addr);

  mux_bus_if #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .prd_n(prd_n),
    .drd_n(drd_n), .wr_n(wr_n), .hi_addr(hi_addr), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_space(rd_space), .rsp_data(rsp_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // ---------------- behavioural reference ----------------
  typedef struct {
    bit ale, cs_n, prd_n, drd_n, wr_n;
    int hi, ad;
  } pin_t;

  pin_t hist[$];
  int   m_hold, m_rdaddr, m_waddr, m_wdata, m_out;
  bit   m_oe, m_rv, m_space, m_wv;

  function automatic pin_t idle_pin();
    pin_t p;
    p.ale = 0; p.cs_n = 1; p.prd_n = 1; p.drd_n = 1; p.wr_n = 1;
    p.hi = 0; p.ad = 0;
    return p;
  endfunction

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < SYNC + 2; i++) hist.push_back(idle_pin());
    m_hold = 0; m_rdaddr = 0; m_waddr = 0; m_wdata = 0; m_out = 0;
    m_oe = 0; m_rv = 0; m_space = 0; m_wv = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      pin_t now, cur, prv;
      int live, addr_now;
      bit rl_c, rl_p;
      now.ale = ale; now.cs_n = cs_n; now.prd_n = prd_n; now.drd_n = drd_n;
      now.wr_n = wr_n; now.hi = int'(hi_addr); now.ad = int'(ad_in);
      hist.push_front(now);
      cur = hist[SYNC];
      prv = hist[SYNC + 1];
      void'(hist.pop_back());
      live     = (cur.hi << 8) | cur.ad;
      addr_now = cur.ale ? live : m_hold;
      if (cur.ale) m_hold = live;
      rl_c = !cur.prd_n || !cur.drd_n;
      rl_p = !prv.prd_n || !prv.drd_n;
      m_out = int'(rsp_f(15'(m_rdaddr)));
      m_oe  = !cur.cs_n && rl_c;
      m_rv  = rl_c && !rl_p && !cur.cs_n;
      if (m_rv) begin
        m_rdaddr = addr_now;
        m_space  = cur.prd_n;
      end
      m_wv = cur.wr_n && !prv.wr_n && !prv.cs_n && !rl_p;
      if (m_wv) begin
        m_waddr = addr_now;
        m_wdata = prv.ad;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("R5", "ad_oe", int'(ad_oe), int'(m_oe));
      if (m_oe) chk("R5", "ad_out", int'(ad_out), m_out);
      chk("R4", "rd_valid", int'(rd_valid), int'(m_rv));
      if (m_rv) begin
        chk("R1", "rd_addr", int'(rd_addr), m_rdaddr);
        chk("R4", "rd_space", int'(rd_space), int'(m_space));
      end
      chk("R6", "wr_valid", int'(wr_valid), int'(m_wv));
      if (m_wv) begin
        chk("R6", "wr_addr", int'(wr_addr), m_waddr);
        chk("R6", "wr_data", int'(wr_data), m_wdata);
      end
      if (rd_valid) rd_seen++;
      if (rd_valid && !rd_space) prog_seen++;
      if (wr_valid) wr_seen++;
    end
  end

  always @(negedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_addr(input logic [14:0] a);
    @(negedge clk);
    ale = 1; hi_addr = a[14:8]; ad_in = a[7:0];
    idle(2);
    ale = 0;
    @(negedge clk);
    ad_in = 8'hEE; hi_addr = 7'h55;  // pins wander after the latch closes
  endtask

  task automatic do_read(input bit prog, input int hold);
    cs_n = 0;
    if (prog) prd_n = 0; else drd_n = 0;
    idle(hold);
    prd_n = 1; drd_n = 1;
    idle(SYNC + 3);
  endtask

  task automatic do_write(input logic [7:0] d0, input logic [7:0] d1);
    cs_n = 0; wr_n = 0; ad_in = d0;
    idle(2);
    ad_in = d1;
    idle(2);
    wr_n = 1;
    @(negedge clk);
    ad_in = 8'h33;
    idle(SYNC + 3);
  endtask

  initial begin
    int r0, w0, p0;
    model_reset();
    idle(3);
    // R9: reset values
    chk("R9", "ad_oe", int'(ad_oe), 0);
    chk("R9", "rd_valid", int'(rd_valid), 0);
    chk("R9", "wr_valid", int'(wr_valid), 0);
    chk("R9", "rd_addr", int'(rd_addr), 0);
    chk("R9", "ad_out", int'(ad_out), 0);
    rst_n = 1;
    idle(SYNC + 2);

    // R8 + R10: program-only reads, measure the latency
    p0 = prog_seen; w0 = wr_seen;
    latch_addr(15'h1234);
    cs_n = 0; prd_n = 0;
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk);
    chk("R10", "rd_valid latency", int'(rd_valid), 1);
    idle(3);
    prd_n = 1;
    idle(SYNC + 3);
    latch_addr(15'h7FFF);
    do_read(1, 4);
    chk("R8", "program reads", prog_seen - p0, 2);
    chk("R8", "no writes", wr_seen - w0, 0);

    // data read, different address pattern
    latch_addr(15'h00A5);
    do_read(0, 5);

    // R6: write, last low-cycle byte wins
    w0 = wr_seen;
    latch_addr(15'h2C01);
    do_write(8'h11, 8'hC3);
    chk("R6", "write count", wr_seen - w0, 1);
    // page-style back-to-back writes
    latch_addr(15'h2C02);
    do_write(8'hA0, 8'hA1);
    latch_addr(15'h2C7F);
    do_write(8'h00, 8'hFF);

    // R3: chip select high blocks both directions
    r0 = rd_seen; w0 = wr_seen;
    latch_addr(15'h4444);
    cs_n = 1; drd_n = 0; idle(4); drd_n = 1; idle(SYNC + 3);
    cs_n = 1; wr_n = 0; ad_in = 8'h77; idle(3); wr_n = 1; idle(SYNC + 3);
    chk("R3", "reads while deselected", rd_seen - r0, 0);
    chk("R3", "writes while deselected", wr_seen - w0, 0);

    // R2: read while the latch is still open reports the live address
    r0 = rd_seen;
    @(negedge clk);
    ale = 1; hi_addr = 7'h3A; ad_in = 8'h5C; cs_n = 0;
    idle(2);
    prd_n = 0;
    idle(SYNC + 2);
    prd_n = 1; ale = 0;
    idle(SYNC + 3);
    chk("R2", "transparent read address", int'(rd_addr), 15'h3A5C);

    // R7: read strobe overlapping the write strobe
    w0 = wr_seen;
    latch_addr(15'h0101);
    cs_n = 0; wr_n = 0; ad_in = 8'h99;
    idle(2);
    drd_n = 0;
    idle(2);
    wr_n = 1;
    idle(2);
    drd_n = 1;
    idle(SYNC + 3);
    chk("R7", "collided write dropped", wr_seen - w0, 0);

    cs_n = 1;
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule